// File: doc/BRIEF.md
# Ethernet Link Mode Resolver

This block settles the operating mode of a 10/100 Ethernet link. When it is enabled it first waits out a fixed start-up delay. It then either applies a forced mode taken from control bits, or listens for the link partner. When the partner sends an ability page, the block intersects that page with the local ability mask and picks the best mode that both sides share. When the partner only sends normal link pulses or 100 Mbps idle symbols, the block detects the partner's speed from those indications and always settles on half duplex.

The outputs are the resolved speed and duplex, a link-valid flag, a symbol-bypass enable and a sticky remote-fault status bit. The remote-fault bit is raised in two cases: when the two ability masks have no mode in common, and when a detected speed lies outside the locally allowed set. A link-loss input drops the link and starts resolution again. A restart input sends the controller back to idle and clears everything. Pulse-burst coding, line coding and the management interface are handled elsewhere; this block receives already-decoded indications.

Top module: `link_mode_resolver`

## Requirements
- R1: The enable is accepted only while both speed-disable inputs are low. `link_up` cannot rise sooner than `STARTUP_CYCLES` cycles after acceptance, and partner indications that arrive during the delay are ignored. Dropping `phy_en` returns the block to idle and clears the link.
- R2: With `an_disable` high, once the delay has run out the link comes up with `speed_100` equal to `force_speed_100` and `full_duplex` equal to `force_full`.
- R3: `bypass_en` is set only in forced mode at 100 Mbps, when `force_bypass` is high. It is never high at 10 Mbps.
- R4: Ability masks use bit 3 for 100 full, bit 2 for 100 half, bit 1 for 10 full and bit 0 for 10 half. On a partner page, the link comes up one cycle later in the highest-numbered mode present in both masks.
- R5: If the masks share no mode, `remote_fault` is set one cycle later and `link_up` stays low until a link loss or a restart.
- R6: With no page present, an idle-symbol indication resolves to 100 half and a link-pulse indication resolves to 10 half, one cycle later. A page takes priority over idle symbols, and idle symbols take priority over link pulses.
- R7: A link brought up by detection also sets `remote_fault` when the detected mode's bit is clear in `local_abil`. Bit 2 is checked for 100 half and bit 0 for 10 half.
- R8: `remote_fault` is sticky. It clears only on `fault_clr` or `restart`, and a new fault event in the same cycle wins over `fault_clr`.
- R9: `link_loss` on an established or failed link drops `link_up` and clears speed and duplex. Resolution then starts over without a new start-up delay.
- R10: `restart` clears the link, the mode, the bypass and the fault in the next cycle, and the start-up delay then runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_en | input | 1 | Enable request |
| an_disable | input | 1 | 1 = forced mode, 0 = negotiated/detected |
| dis_100 | input | 1 | Speed-disable bit, must be 0 to enable |
| dis_10 | input | 1 | Speed-disable bit, must be 0 to enable |
| force_speed_100 | input | 1 | Forced speed select (1 = 100 Mbps) |
| force_full | input | 1 | Forced duplex select (1 = full) |
| force_bypass | input | 1 | Symbol-mode bypass request in forced mode |
| local_abil | input | 4 | Local ability mask |
| partner_abil | input | 4 | Partner ability mask |
| partner_abil_valid | input | 1 | Partner page received this cycle |
| nlp_seen | input | 1 | Normal link pulses detected |
| idle100_seen | input | 1 | 100 Mbps idle symbols detected |
| link_loss | input | 1 | Link lost, restart resolution |
| restart | input | 1 | Return to idle and clear state |
| fault_clr | input | 1 | Read-clear pulse for remote fault |
| speed_100 | output | 1 | Resolved speed (1 = 100 Mbps) |
| full_duplex | output | 1 | Resolved duplex (1 = full) |
| link_up | output | 1 | Link valid |
| remote_fault | output | 1 | Sticky remote-fault status |
| bypass_en | output | 1 | Symbol-mode bypass active |

## Verification
Several checks run on every cycle. The assertions verify that bypass never appears at 10 Mbps, that a detected link is never full duplex, and that a page with no shared mode raises the fault and keeps the link down. They also verify that the fault holds until it is cleared, that a link loss or restart empties the mode in the next cycle, and that the link cannot rise straight out of the start-up wait. Other properties need planned stimulus and expected values, so only the bench scenarios can show them. These are the choice of the highest common mode across many random mask pairs, the exact number of cycles the start-up delay takes, the rejection of an enable while a speed-disable bit is set, the priority among simultaneous indications, and re-resolution after a link loss.

// File: rtl/lmr_pkg.sv
// Shared types for the link mode resolver.
// Mode index i in an ability mask: bit 1 of i = 100 Mbps, bit 0 of i = full duplex.
package lmr_pkg;
    localparam int NUM_MODES = 4;
    localparam int IDX_W     = $clog2(NUM_MODES);

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_FORCE,
        S_LISTEN,
        S_LINKED,
        S_NOMATCH
    } lmr_state_t;
endpackage

// File: rtl/lmr_startup_timer.sv
// Start-up delay counter. Counts while run is high and raises done on the
// last cycle of a LIMIT-cycle window. It restarts from zero whenever run drops.
// Assumes LIMIT >= 1.
module lmr_startup_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [W-1:0] cnt;

    assign done = run && (cnt == W'(LIMIT - 1));

    // Advance the count while running; hold at the end; clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lmr_ability_pick.sv
// Combinational pick of the highest mode present in both ability masks.
// Assumes the mask encoding from lmr_pkg; a higher index means a better mode.
module lmr_ability_pick
    import lmr_pkg::*;
(
    input  logic [NUM_MODES-1:0] local_mask,
    input  logic [NUM_MODES-1:0] partner_mask,
    output logic                 any_common,
    output logic [IDX_W-1:0]     best_idx
);
    logic [NUM_MODES-1:0] common;
    logic [NUM_MODES-1:0] top_bit;

    assign common     = local_mask & partner_mask;
    assign any_common = |common;

    // Keep a common bit only when no higher common bit exists.
    generate
        for (genvar g = 0; g < NUM_MODES; g++) begin : g_top
            if (g == NUM_MODES - 1) begin : g_last
                assign top_bit[g] = common[g];
            end else begin : g_rest
                assign top_bit[g] = common[g] && !(|common[NUM_MODES-1:g+1]);
            end
        end
    endgenerate

    // Encode the single surviving bit as a mode index.
    always_comb begin
        best_idx = '0;
        for (int i = 0; i < NUM_MODES; i++) begin
            if (top_bit[i]) best_idx = IDX_W'(i);
        end
    end

    always_comb begin
        assert_single_pick_R4: assert ($onehot0(top_bit));
    end
endmodule

// File: rtl/lmr_fault_flag.sv
// Sticky remote-fault bit. Restart clears it first. A set event wins over
// the read-clear pulse, so no fault raised in the same cycle is lost.
module lmr_fault_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic set_evt,
    input  logic clr_pulse,
    output logic fault
);
    // Hold the fault until it is explicitly cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            fault <= 1'b0;
        end else if (set_evt) begin
            fault <= 1'b1;
        end else if (clr_pulse) begin
            fault <= 1'b0;
        end
    end

    assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !clr_pulse && !restart) |=> fault);
endmodule

// File: rtl/link_mode_resolver.sv
// Ethernet 10/100 link mode resolver.
// After an accepted enable and the start-up delay, it either applies the
// forced mode or resolves the mode from the partner page or from link
// pulse / idle indications. Assumes all inputs are synchronous to clk and
// that the indications are already decoded upstream.
module link_mode_resolver
    import lmr_pkg::*;
#(
    parameter int STARTUP_CYCLES = 1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 phy_en,
    input  logic                 an_disable,
    input  logic                 dis_100,
    input  logic                 dis_10,
    input  logic                 force_speed_100,
    input  logic                 force_full,
    input  logic                 force_bypass,
    input  logic [NUM_MODES-1:0] local_abil,
    input  logic [NUM_MODES-1:0] partner_abil,
    input  logic                 partner_abil_valid,
    input  logic                 nlp_seen,
    input  logic                 idle100_seen,
    input  logic                 link_loss,
    input  logic                 restart,
    input  logic                 fault_clr,
    output logic                 speed_100,
    output logic                 full_duplex,
    output logic                 link_up,
    output logic                 remote_fault,
    output logic                 bypass_en
);
    localparam int IDX_100H = 2;
    localparam int IDX_10H  = 0;

    lmr_state_t       state;
    logic             cfg_ok;
    logic             tmr_done;
    logic             any_common;
    logic [IDX_W-1:0] best_idx;
    logic             fault_set;

    assign cfg_ok = phy_en && !dis_100 && !dis_10;

    lmr_startup_timer #(.LIMIT(STARTUP_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == S_WAIT && cfg_ok && !restart),
        .done  (tmr_done)
    );

    lmr_ability_pick u_pick (
        .local_mask   (local_abil),
        .partner_mask (partner_abil),
        .any_common   (any_common),
        .best_idx     (best_idx)
    );

    // Raise a fault on an empty intersection or on a detected mode that is not allowed.
    always_comb begin
        fault_set = 1'b0;
        if (phy_en && !restart && state == S_LISTEN) begin
            if (partner_abil_valid)  fault_set = !any_common;
            else if (idle100_seen)   fault_set = !local_abil[IDX_100H];
            else if (nlp_seen)       fault_set = !local_abil[IDX_10H];
        end
    end

    lmr_fault_flag u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .set_evt   (fault_set),
        .clr_pulse (fault_clr),
        .fault     (remote_fault)
    );

    // Control sequence and resolved-mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !phy_en) begin
            state       <= S_IDLE;
            speed_100   <= 1'b0;
            full_duplex <= 1'b0;
            link_up     <= 1'b0;
            bypass_en   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (cfg_ok) state <= S_WAIT;
                end
                S_WAIT: begin
                    if (!cfg_ok)       state <= S_IDLE;
                    else if (tmr_done) state <= an_disable ? S_FORCE : S_LISTEN;
                end
                S_FORCE: begin
                    speed_100   <= force_speed_100;
                    full_duplex <= force_full;
                    bypass_en   <= force_speed_100 && force_bypass;
                    link_up     <= 1'b1;
                    state       <= S_LINKED;
                end
                S_LISTEN: begin
                    if (partner_abil_valid) begin
                        if (any_common) begin
                            speed_100   <= best_idx[1];
                            full_duplex <= best_idx[0];
                            link_up     <= 1'b1;
                            state       <= S_LINKED;
                        end else begin
                            state <= S_NOMATCH;
                        end
                    end else if (idle100_seen) begin
                        speed_100   <= 1'b1;
                        full_duplex <= 1'b0;
                        link_up     <= 1'b1;
                        state       <= S_LINKED;
                    end else if (nlp_seen) begin
                        speed_100   <= 1'b0;
                        full_duplex <= 1'b0;
                        link_up     <= 1'b1;
                        state       <= S_LINKED;
                    end
                end
                S_LINKED, S_NOMATCH: begin
                    if (link_loss) begin
                        speed_100   <= 1'b0;
                        full_duplex <= 1'b0;
                        link_up     <= 1'b0;
                        bypass_en   <= 1'b0;
                        state       <= an_disable ? S_FORCE : S_LISTEN;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assert_bypass_only_100_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_en |-> speed_100);

    assert_detect_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LISTEN && phy_en && !restart && !partner_abil_valid
         && (idle100_seen || nlp_seen)) |=> (link_up && !full_duplex));

    assert_no_common_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LISTEN && phy_en && !restart && partner_abil_valid
         && ((local_abil & partner_abil) == '0)) |=> (remote_fault && !link_up));

    assert_loss_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && link_loss) |=> (!link_up && !speed_100 && !full_duplex));

    assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!link_up && !remote_fault && !speed_100 && !full_duplex && !bypass_en));

    assert_no_early_link_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> ($past(state) != S_WAIT && $past(state) != S_IDLE));
endmodule

// File: tb/sim_link_mode_resolver.sv
module sim_link_mode_resolver;
    localparam int LIM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phy_en = 0, an_disable = 0, dis_100 = 0, dis_10 = 0;
    logic force_speed_100 = 0, force_full = 0, force_bypass = 0;
    logic [3:0] local_abil = 4'hF, partner_abil = 4'h0;
    logic partner_abil_valid = 0, nlp_seen = 0, idle100_seen = 0;
    logic link_loss = 0, restart = 0, fault_clr = 0;
    logic speed_100, full_duplex, link_up, remote_fault, bypass_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    link_mode_resolver #(.STARTUP_CYCLES(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .phy_en(phy_en), .an_disable(an_disable),
        .dis_100(dis_100), .dis_10(dis_10), .force_speed_100(force_speed_100),
        .force_full(force_full), .force_bypass(force_bypass),
        .local_abil(local_abil), .partner_abil(partner_abil),
        .partner_abil_valid(partner_abil_valid), .nlp_seen(nlp_seen),
        .idle100_seen(idle100_seen), .link_loss(link_loss), .restart(restart),
        .fault_clr(fault_clr), .speed_100(speed_100), .full_duplex(full_duplex),
        .link_up(link_up), .remote_fault(remote_fault), .bypass_en(bypass_en)
    );

    // Outputs packed as {link, speed, duplex, fault, bypass}.
    function automatic logic [4:0] outs();
        return {link_up, speed_100, full_duplex, remote_fault, bypass_en};
    endfunction

    // Expected {link, speed, duplex, fault} for a partner page.
    function automatic logic [3:0] exp_page(logic [3:0] l, logic [3:0] p);
        for (int i = 3; i >= 0; i--) begin
            if (l[i] && p[i]) return {1'b1, 1'(i >> 1), 1'(i & 1), 1'b0};
        end
        return 4'b0001;
    endfunction

    task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b (link,spd,fdx,flt,byp)", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_restart();
        restart = 1;
        step(1);
        restart = 0;
    endtask

    task automatic bring_up();
        step(LIM + 3);
    endtask

    task automatic pulse_page(logic [3:0] p);
        partner_abil = p;
        partner_abil_valid = 1;
        step(1);
        partner_abil_valid = 0;
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [3:0] e;
        logic [3:0] l;
        logic [3:0] p;
        int kind;
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1;
        step(1);
        chk("reset", outs(), 5'b00000);

        // R1: enable refused while a speed-disable bit is set
        an_disable = 1; force_speed_100 = 1; force_full = 0; force_bypass = 1;
        dis_100 = 1; phy_en = 1;
        step(LIM + 6);
        chk("R1 disable bit blocks enable", outs(), 5'b00000);
        dis_100 = 0;
        step(LIM);
        chk("R1 no link before delay", outs(), 5'b00000);
        step(2);
        chk("R2 R3 forced 100 half bypass", outs(), 5'b11001);

        // R3: 10 Mbps forced never bypasses
        force_speed_100 = 0; force_full = 1; force_bypass = 1;
        do_restart();
        chk("R10 restart clears", outs(), 5'b00000);
        bring_up();
        chk("R2 R3 forced 10 full no bypass", outs(), 5'b10100);

        // R1: dropping enable clears the link
        phy_en = 0;
        step(1);
        chk("R1 enable drop", outs(), 5'b00000);
        phy_en = 1;

        // R1: indications during the delay are ignored
        an_disable = 0; local_abil = 4'hF;
        step(2);
        pulse_page(4'hF);
        idle100_seen = 1;
        step(1);
        idle100_seen = 0;
        bring_up();
        chk("R1 ignored during delay", outs(), 5'b00000);

        // R6: page wins over idle symbols
        partner_abil = 4'b0010; partner_abil_valid = 1; idle100_seen = 1;
        step(1);
        partner_abil_valid = 0; idle100_seen = 0;
        chk("R6 page priority", outs(), 5'b10100);

        // R9: link loss, then re-resolve by link pulses
        link_loss = 1;
        step(1);
        link_loss = 0;
        chk("R9 loss clears", outs(), 5'b00000);
        nlp_seen = 1; idle100_seen = 1;
        step(1);
        nlp_seen = 0; idle100_seen = 0;
        chk("R6 idle over pulses", outs(), 5'b11000);

        // R7: detected mode not allowed
        do_restart();
        local_abil = 4'b1011;
        bring_up();
        idle100_seen = 1;
        step(1);
        idle100_seen = 0;
        chk("R7 detect not allowed", outs(), 5'b11010);

        // R8: sticky through loss, then read-clear
        link_loss = 1;
        step(1);
        link_loss = 0;
        step(4);
        chk("R8 fault sticky", outs(), 5'b00010);
        fault_clr = 1;
        step(1);
        fault_clr = 0;
        chk("R8 fault cleared", outs(), 5'b00000);

        // R5: no common mode, then R8 set beats clear
        local_abil = 4'b0011;
        partner_abil = 4'b1100; partner_abil_valid = 1; fault_clr = 1;
        step(1);
        partner_abil_valid = 0; fault_clr = 0;
        chk("R5 R8 no common fault", outs(), 5'b00010);
        pulse_page(4'b0011);
        chk("R5 held down until loss", outs(), 5'b00010);

        // Random mix of pages and detections
        for (int it = 0; it < 150; it++) begin
            do_restart();
            bring_up();
            l = 4'($urandom());
            p = 4'($urandom());
            local_abil = l;
            kind = $urandom_range(0, 2);
            if (kind == 0) begin
                pulse_page(p);
                e = exp_page(l, p);
                chk("R4 R5 random page", outs(), {e, 1'b0});
            end else if (kind == 1) begin
                idle100_seen = 1;
                step(1);
                idle100_seen = 0;
                chk("R6 R7 random idle", outs(), {3'b110, !l[2], 1'b0});
            end else begin
                nlp_seen = 1;
                step(1);
                nlp_seen = 0;
                chk("R6 R7 random pulses", outs(), {3'b100, !l[0], 1'b0});
            end
            if (it % 5 == 0) begin
                e[0] = remote_fault;
                link_loss = 1;
                step(1);
                link_loss = 0;
                chk("R9 random loss", outs(), {4'b0000, e[0]} << 1);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule